// File: doc/BRIEF.md
# Two-Wide In-Order Issue Stage with Integer/FP Slot Pairing

This block sits between instruction fetch and the execution pipes of a two-wide, in-order processor. Each cycle fetch offers a 64-bit packet of two 32-bit instructions. The lower half is the left slot, meant for integer-class work: ALU operations and all memory accesses, including those that move floating-point data. The upper half is the right slot, meant for floating-point arithmetic only. The block decodes both instructions, checks the slots against their intended classes, compares all six register fields against each other and against a scoreboard of registers still being produced, and then sends out none, one or both instructions. The result is presented in program order on two output lanes.

The right instruction never goes out without the left one. When the left one issues and the right one cannot, the block parks the right one in a one-entry hold register and stops taking fetch packets. The held instruction then goes out alone as soon as its sources are ready. The fetch side keeps offering the same packet until `fetch_adv` is high. A scoreboard of 64 pending bits (32 integer and 32 floating-point registers) is set when an instruction that writes a register issues, and cleared by the completion inputs.

Top module: `pair_issue_unit`

## Requirements
- R1: While reset is applied, and in the cycles after release until the internal reset synchronizer lets go, no lane is valid and `fetch_adv` is low. After reset no register is pending and the hold register is empty.
- R2: Instruction fields: opcode is bits [31:26], destination is [25:21], first source is [20:16], second source is [15:11]. An all-zero opcode marks an empty slot. Opcode bits [31:30]=11 is FP arithmetic: it reads two FP registers and writes one. Bits [31:30]=01 is a memory access: it reads an integer base from the first source, and bits [27:26] select the kind: 00 integer load (writes integer destination), 01 integer store (reads integer second source), 10 FP load (writes FP destination), 11 FP store (reads FP second source). Any other non-zero opcode is an integer ALU operation that reads both integer sources and writes the integer destination. Integer register 0 is never read as a dependence and is never written. The left slot is packet bits [31:0] and the right slot is bits [63:32].
- R3: When the left slot holds a non-FP-arithmetic instruction and the right slot holds FP arithmetic, and there is no hazard, both issue in the same cycle. The left one goes on the first lane, the right one on the second lane, and `fetch_adv` is high.
- R4: The second lane is valid only in a cycle where the packet's left slot also issues or is empty. If the left instruction is stalled, nothing issues and `fetch_adv` stays low.
- R5: If the right slot holds anything other than FP arithmetic, or the left slot holds FP arithmetic, only the left instruction issues and the right one is parked.
- R6: If the right instruction reads the register that the left instruction writes, only the left one issues and the right one is parked.
- R7: Issuing an instruction that writes a register makes that register pending from the next cycle on. A completion clears its register from the next cycle on. If a completion and a new issue name the same register in one cycle, the register stays pending.
- R8: An instruction with any pending source register does not issue. This applies to left, right and held instructions.
- R9: While an instruction is held, `fetch_adv` is low and the held instruction is the only candidate. It goes out alone on the first lane once its sources are free, and the hold register empties.
- R10: An empty slot issues nothing, never blocks and is never parked. An empty left slot with FP arithmetic on the right issues the right one alone on the second lane.
- R11: An FP load or FP store in the left slot pairs with FP arithmetic in the right slot when there is no dependence between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fetch_valid | input | 1 | A fetch packet is offered |
| fetch_pkt | input | 64 | Left instruction in [31:0], right instruction in [63:32] |
| fetch_adv | output | 1 | The offered packet is consumed this cycle |
| done_int_valid | input | 1 | An integer register result has completed |
| done_int_idx | input | 5 | Index of the completed integer register |
| done_fp_valid | input | 1 | An FP register result has completed |
| done_fp_idx | input | 5 | Index of the completed FP register |
| first_valid | output | 1 | First (older) issue lane is valid |
| first_instr | output | 32 | Instruction on the first lane |
| second_valid | output | 1 | Second (younger) issue lane is valid |
| second_instr | output | 32 | Instruction on the second lane |

## Verification
A scoreboard bit that is wrongly set or wrongly cleared shows up at the lanes in the very cycle a reader of that register is presented: the reader is either missing or issued early. A bad hold-register state shows up one cycle after the split. Either the parked instruction never appears on the first lane while `fetch_adv` stays low, or fetch advances past an instruction that was never issued. The bench compares every lane and `fetch_adv` on every cycle against a behavioural model, so any such divergence is reported in the cycle it first reaches the ports.

// File: rtl/pair_issue_pkg.sv
`timescale 1ns/1ps
package pair_issue_pkg;
  localparam int ILEN    = 32;
  localparam int PKT_W   = 2 * ILEN;
  localparam int OPC_W   = 6;
  localparam int RIDX_W  = 5;
  localparam int SPEC_W  = RIDX_W + 1;
  localparam int NSPEC   = 1 << SPEC_W;
  localparam int OPC_LSB = ILEN - OPC_W;
  localparam int RD_LSB  = OPC_LSB - RIDX_W;
  localparam int RS1_LSB = RD_LSB - RIDX_W;
  localparam int RS2_LSB = RS1_LSB - RIDX_W;
  localparam int DEC_LSB = RS2_LSB;

  // register specifier: MSB selects the FP file
  typedef logic [SPEC_W-1:0] spec_t;

  typedef struct packed {
    logic  live;
    logic  fp_arith;
    logic  wr;
    spec_t dst;
    logic  rd_a;
    spec_t src_a;
    logic  rd_b;
    spec_t src_b;
  } slot_info_t;
endpackage

// File: rtl/pi_slot_decode.sv
`timescale 1ns/1ps
module pi_slot_decode
  import pair_issue_pkg::*;
(
  input  logic [ILEN-1:DEC_LSB] word_i,
  output slot_info_t            info_o
);
  logic [OPC_W-1:0]  opc;
  logic [RIDX_W-1:0] f_rd;
  logic [RIDX_W-1:0] f_a;
  logic [RIDX_W-1:0] f_b;

  assign opc  = word_i[ILEN-1:OPC_LSB];
  assign f_rd = word_i[OPC_LSB-1:RD_LSB];
  assign f_a  = word_i[RD_LSB-1:RS1_LSB];
  assign f_b  = word_i[RS1_LSB-1:RS2_LSB];

  always_comb begin
    info_o = '0;
    if (opc != '0) begin
      info_o.live = 1'b1;
      case (opc[OPC_W-1 -: 2])
        2'b11: begin
          info_o.fp_arith = 1'b1;
          info_o.wr       = 1'b1;
          info_o.dst      = {1'b1, f_rd};
          info_o.rd_a     = 1'b1;
          info_o.src_a    = {1'b1, f_a};
          info_o.rd_b     = 1'b1;
          info_o.src_b    = {1'b1, f_b};
        end
        2'b01: begin
          info_o.rd_a  = (f_a != '0);
          info_o.src_a = {1'b0, f_a};
          case (opc[1:0])
            2'b00: begin
              info_o.wr  = (f_rd != '0);
              info_o.dst = {1'b0, f_rd};
            end
            2'b01: begin
              info_o.rd_b  = (f_b != '0);
              info_o.src_b = {1'b0, f_b};
            end
            2'b10: begin
              info_o.wr  = 1'b1;
              info_o.dst = {1'b1, f_rd};
            end
            default: begin
              info_o.rd_b  = 1'b1;
              info_o.src_b = {1'b1, f_b};
            end
          endcase
        end
        default: begin
          info_o.rd_a  = (f_a != '0);
          info_o.src_a = {1'b0, f_a};
          info_o.rd_b  = (f_b != '0);
          info_o.src_b = {1'b0, f_b};
          info_o.wr    = (f_rd != '0);
          info_o.dst   = {1'b0, f_rd};
        end
      endcase
    end
  end
endmodule

// File: rtl/pi_scoreboard.sv
`timescale 1ns/1ps
module pi_scoreboard
  import pair_issue_pkg::*;
#(
  parameter  int NREG = NSPEC,
  localparam int IW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set0_en,
  input  logic [IW-1:0]   set0_idx,
  input  logic            set1_en,
  input  logic [IW-1:0]   set1_idx,
  input  logic            clr0_en,
  input  logic [IW-1:0]   clr0_idx,
  input  logic            clr1_en,
  input  logic [IW-1:0]   clr1_idx,
  output logic [NREG-1:0] busy_o
);
  logic [NREG-1:0] busy_q;
  logic [NREG-1:0] busy_n;

  for (genvar i = 0; i < NREG; i++) begin : g_bit
    logic hit_set;
    logic hit_clr;
    assign hit_set = (set0_en && set0_idx == IW'(i)) || (set1_en && set1_idx == IW'(i));
    assign hit_clr = (clr0_en && clr0_idx == IW'(i)) || (clr1_en && clr1_idx == IW'(i));
    assign busy_n[i] = hit_set | (busy_q[i] & ~hit_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= '0;
    else        busy_q <= busy_n;
  end

  assign busy_o = busy_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set0_en |=> busy_o[$past(set0_idx)]);

  // R7
  clear_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0_en && !(set0_en && set0_idx == clr0_idx) && !(set1_en && set1_idx == clr0_idx))
      |=> !busy_o[$past(clr0_idx)]);
endmodule

// File: rtl/pi_pair_arbiter.sv
`timescale 1ns/1ps
module pi_pair_arbiter
  import pair_issue_pkg::*;
(
  input  logic             run,
  input  logic             hold_v,
  input  slot_info_t       hold_i,
  input  logic             fetch_v,
  input  slot_info_t       left_i,
  input  slot_info_t       right_i,
  input  logic [NSPEC-1:0] busy,
  output slot_info_t       first_info,
  output logic             first_go,
  output logic             second_go,
  output logic             take,
  output logic             park
);
  function automatic logic src_wait(input slot_info_t s, input logic [NSPEC-1:0] b);
    return (s.rd_a && b[s.src_a]) || (s.rd_b && b[s.src_b]);
  endfunction

  logic left_go;
  logic raw_in_pair;
  logic class_ok;
  logic pair_ok;

  assign raw_in_pair = left_i.wr &&
                       ((right_i.rd_a && right_i.src_a == left_i.dst) ||
                        (right_i.rd_b && right_i.src_b == left_i.dst));
  assign class_ok    = right_i.fp_arith && !left_i.fp_arith;
  assign pair_ok     = right_i.live && class_ok && !raw_in_pair && !src_wait(right_i, busy);
  assign left_go     = !src_wait(left_i, busy);
  assign first_info  = hold_v ? hold_i : left_i;

  always_comb begin
    first_go  = 1'b0;
    second_go = 1'b0;
    take      = 1'b0;
    park      = 1'b0;
    if (run) begin
      if (hold_v) begin
        first_go = !src_wait(hold_i, busy);
      end else if (fetch_v) begin
        take      = left_go;
        first_go  = left_go && left_i.live;
        second_go = left_go && pair_ok;
        park      = left_go && right_i.live && !pair_ok;
      end
    end
  end
endmodule

// File: rtl/pair_issue_unit.sv
`timescale 1ns/1ps
module pair_issue_unit
  import pair_issue_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [PKT_W-1:0]  fetch_pkt,
  output logic              fetch_adv,
  input  logic              done_int_valid,
  input  logic [RIDX_W-1:0] done_int_idx,
  input  logic              done_fp_valid,
  input  logic [RIDX_W-1:0] done_fp_idx,
  output logic              first_valid,
  output logic [ILEN-1:0]   first_instr,
  output logic              second_valid,
  output logic [ILEN-1:0]   second_instr
);
  localparam int NWORD   = 3;
  localparam int SL_LEFT = 0;
  localparam int SL_RGT  = 1;
  localparam int SL_HOLD = 2;

  logic rs_meta;
  logic run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) {run, rs_meta} <= 2'b00;
    else        {run, rs_meta} <= {rs_meta, 1'b1};
  end

  logic [ILEN-1:0] left_w;
  logic [ILEN-1:0] right_w;
  logic [ILEN-1:0] hold_w_q;
  logic            hold_v_q;
  logic            hold_v_n;

  assign left_w  = fetch_pkt[ILEN-1:0];
  assign right_w = fetch_pkt[PKT_W-1:ILEN];

  logic [NWORD-1:0][ILEN-1:DEC_LSB] dec_in;
  slot_info_t info [NWORD];

  assign dec_in[SL_LEFT] = left_w[ILEN-1:DEC_LSB];
  assign dec_in[SL_RGT]  = right_w[ILEN-1:DEC_LSB];
  assign dec_in[SL_HOLD] = hold_w_q[ILEN-1:DEC_LSB];

  for (genvar g = 0; g < NWORD; g++) begin : g_dec
    pi_slot_decode u_dec (
      .word_i (dec_in[g]),
      .info_o (info[g])
    );
  end

  logic [NSPEC-1:0] busy;
  slot_info_t       first_info;
  logic             first_go;
  logic             second_go;
  logic             take;
  logic             park;

  pi_pair_arbiter u_arb (
    .run        (run),
    .hold_v     (hold_v_q),
    .hold_i     (info[SL_HOLD]),
    .fetch_v    (fetch_valid),
    .left_i     (info[SL_LEFT]),
    .right_i    (info[SL_RGT]),
    .busy       (busy),
    .first_info (first_info),
    .first_go   (first_go),
    .second_go  (second_go),
    .take       (take),
    .park       (park)
  );

  pi_scoreboard #(.NREG(NSPEC)) u_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set0_en  (first_go && first_info.wr),
    .set0_idx (first_info.dst),
    .set1_en  (second_go && info[SL_RGT].wr),
    .set1_idx (info[SL_RGT].dst),
    .clr0_en  (done_int_valid),
    .clr0_idx ({1'b0, done_int_idx}),
    .clr1_en  (done_fp_valid),
    .clr1_idx ({1'b1, done_fp_idx}),
    .busy_o   (busy)
  );

  always_comb begin
    hold_v_n = hold_v_q;
    if (park)                      hold_v_n = 1'b1;
    else if (hold_v_q && first_go) hold_v_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_v_q <= 1'b0;
    else        hold_v_q <= hold_v_n;
  end

  always_ff @(posedge clk) begin
    if (park) hold_w_q <= right_w;
  end

  assign fetch_adv    = take;
  assign first_valid  = first_go;
  assign first_instr  = hold_v_q ? hold_w_q : left_w;
  assign second_valid = second_go;
  assign second_instr = right_w;

  // R4
  second_needs_first_chk: assert property (@(posedge clk) disable iff (!run)
    second_valid |-> fetch_adv);

  // R9
  hold_stalls_fetch_chk: assert property (@(posedge clk) disable iff (!run)
    hold_v_q |-> !fetch_adv);

  // R5
  second_lane_class_chk: assert property (@(posedge clk) disable iff (!run)
    second_valid |-> (second_instr[ILEN-1 -: 2] == 2'b11 && first_instr[ILEN-1 -: 2] != 2'b11));

  // R9
  park_origin_chk: assert property (@(posedge clk) disable iff (!run)
    $rose(hold_v_q) |-> $past(fetch_valid && fetch_adv && !second_valid));
endmodule

// File: tb/sim_pair_issue_unit.sv
`timescale 1ns/1ps
module sim_pair_issue_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        fetch_valid;
  logic [63:0] fetch_pkt;
  logic        fetch_adv;
  logic        done_int_valid;
  logic [4:0]  done_int_idx;
  logic        done_fp_valid;
  logic [4:0]  done_fp_idx;
  logic        first_valid;
  logic [31:0] first_instr;
  logic        second_valid;
  logic [31:0] second_instr;

  always #2.5 clk = ~clk;

  pair_issue_unit u0 (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_pkt(fetch_pkt),
    .fetch_adv(fetch_adv), .done_int_valid(done_int_valid), .done_int_idx(done_int_idx),
    .done_fp_valid(done_fp_valid), .done_fp_idx(done_fp_idx), .first_valid(first_valid),
    .first_instr(first_instr), .second_valid(second_valid), .second_instr(second_instr)
  );

  localparam logic [5:0] OP_ALU = 6'h01, OP_LD = 6'h10, OP_ST = 6'h11,
                         OP_FLD = 6'h12, OP_FST = 6'h13, OP_FOP = 6'h30;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          finished = 0;
  bit          pend [64];
  bit          hv = 0;
  logic [31:0] hw = '0;
  bit          last_adv = 0;

  function automatic logic [31:0] ins(logic [5:0] op, int rd, int a, int b);
    return {op, 5'(rd), 5'(a), 5'(b), 11'd0};
  endfunction

  function automatic void look(input logic [31:0] w, output bit emp, output bit fpa,
                               output int dst, output int sa, output int sb);
    logic [5:0] op = w[31:26];
    int rd = int'(w[25:21]);
    int a  = int'(w[20:16]);
    int b  = int'(w[15:11]);
    emp = (op == 6'd0); fpa = 0; dst = -1; sa = -1; sb = -1;
    if (emp) return;
    if (op[5:4] == 2'b11) begin
      fpa = 1; dst = 32 + rd; sa = 32 + a; sb = 32 + b;
    end else if (op[5:4] == 2'b01) begin
      sa = (a != 0) ? a : -1;
      if (op[1:0] == 2'b00)      dst = (rd != 0) ? rd : -1;
      else if (op[1:0] == 2'b01) sb = (b != 0) ? b : -1;
      else if (op[1:0] == 2'b10) dst = 32 + rd;
      else                       sb = 32 + b;
    end else begin
      sa = (a != 0) ? a : -1; sb = (b != 0) ? b : -1; dst = (rd != 0) ? rd : -1;
    end
  endfunction

  function automatic bit waiting(int s);
    return (s >= 0) && pend[s];
  endfunction

  task automatic tick(bit fv, logic [63:0] pkt, bit di, int dix, bit df, int dfx);
    bit eav = 0, ebv = 0, eadv = 0, do_park = 0;
    logic [31:0] ea = '0, eb = '0;
    logic [31:0] lw = pkt[31:0], rw = pkt[63:32];
    int dA = -1, dB = -1;
    string why;
    bit le, lf, re, rf, ok;
    int ld, l1, l2, rd, r1, r2;
    @(negedge clk);
    fetch_valid = fv; fetch_pkt = pkt;
    done_int_valid = di; done_int_idx = 5'(dix);
    done_fp_valid = df;  done_fp_idx = 5'(dfx);
    #1;
    if (hv) begin
      look(hw, le, lf, ld, l1, l2);
      eav = !(waiting(l1) || waiting(l2)); ea = hw;
      if (eav) dA = ld;
      why = eav ? "R9 held instruction goes alone" : "R8 held source pending";
    end else if (fv) begin
      look(lw, le, lf, ld, l1, l2);
      look(rw, re, rf, rd, r1, r2);
      if (waiting(l1) || waiting(l2)) begin
        why = "R4 R8 left stalled, nothing issues";
      end else begin
        eadv = 1; eav = !le; ea = lw;
        if (eav) dA = ld;
        if (re) why = "R10 empty right slot";
        else if (!rf || lf) why = "R2 R5 slot class mismatch";
        else if (ld >= 0 && (r1 == ld || r2 == ld)) why = "R6 dependence inside pair";
        else if (waiting(r1) || waiting(r2)) why = "R7 R8 right source pending";
        else begin
          ebv = 1; eb = rw; dB = rd;
          why = le ? "R10 empty left, right alone" : "R3 R11 pair issues together";
        end
        do_park = !re && !ebv;
      end
    end else begin
      why = "R1 nothing offered";
    end
    ok = (first_valid === eav) && (second_valid === ebv) && (fetch_adv === eadv) &&
         (!eav || first_instr === ea) && (!ebv || second_instr === eb);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual v=%b%b adv=%b a=%h b=%h expected v=%b%b adv=%b a=%h b=%h",
               why, first_valid, second_valid, fetch_adv, first_instr, second_instr,
               eav, ebv, eadv, ea, eb);
    end
    if (di) pend[dix] = 0;
    if (df) pend[32 + dfx] = 0;
    if (dA >= 0) pend[dA] = 1;
    if (dB >= 0) pend[dB] = 1;
    if (hv && eav) hv = 0;
    else if (do_park) begin hv = 1; hw = rw; end
    last_adv = eadv;
  endtask

  task automatic drain();
    for (int i = 0; i < 32; i++) tick(0, '0, 1, i, 1, i);
  endtask

  function automatic logic [31:0] rnd_left();
    int k = $urandom_range(0, 9);
    int a = $urandom_range(0, 3), b = $urandom_range(0, 3), d = $urandom_range(0, 3);
    case (k)
      0, 1: return ins(OP_ALU, d, a, b);
      2:    return ins(OP_LD, d, a, b);
      3:    return ins(OP_ST, d, a, b);
      4, 5: return ins(OP_FLD, d, a, b);
      6:    return ins(OP_FST, d, a, b);
      7:    return ins(OP_FOP, d, a, b);
      default: return '0;
    endcase
  endfunction

  function automatic logic [31:0] rnd_right();
    int k = $urandom_range(0, 9);
    int a = $urandom_range(0, 3), b = $urandom_range(0, 3), d = $urandom_range(0, 3);
    if (k < 7)  return ins(OP_FOP, d, a, b);
    if (k == 7) return ins(OP_ALU, d, a, b);
    if (k == 8) return ins(OP_LD, d, a, b);
    return '0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual still running, expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [63:0] cur;
    for (int i = 0; i < 64; i++) pend[i] = 0;
    rst_n = 0; fetch_valid = 1; fetch_pkt = {ins(OP_FOP, 1, 2, 3), ins(OP_ALU, 1, 2, 3)};
    done_int_valid = 0; done_int_idx = '0; done_fp_valid = 0; done_fp_idx = '0;
    repeat (3) @(negedge clk);
    #1;
    n_chk++;
    if (first_valid !== 1'b0 || second_valid !== 1'b0 || fetch_adv !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: actual v=%b%b adv=%b expected v=00 adv=0",
               first_valid, second_valid, fetch_adv);
    end
    @(negedge clk); rst_n = 1; fetch_valid = 0;
    repeat (3) tick(0, '0, 0, 0, 0, 0);

    // R3 dual issue, then R8 right source pending -> park
    tick(1, {ins(OP_FOP, 1, 2, 3), ins(OP_ALU, 1, 2, 3)}, 0, 0, 0, 0);
    tick(1, {ins(OP_FOP, 4, 1, 5), ins(OP_ALU, 6, 7, 0)}, 0, 0, 0, 0);
    // R9 held blocked, cleared, then issued alone
    cur = {ins(OP_FOP, 7, 8, 9), ins(OP_ALU, 10, 1, 2)};
    tick(1, cur, 0, 0, 0, 0);
    tick(1, cur, 0, 0, 1, 1);
    tick(1, cur, 0, 0, 0, 0);
    // R4 left waits on r1
    tick(1, cur, 0, 0, 0, 0);
    tick(1, cur, 1, 1, 0, 0);
    tick(1, cur, 0, 0, 0, 0);
    drain();
    // R5 class mismatches
    tick(1, {ins(OP_ALU, 14, 12, 13), ins(OP_ALU, 11, 12, 13)}, 0, 0, 0, 0);
    tick(0, '0, 0, 0, 0, 0);
    tick(1, {ins(OP_FOP, 16, 3, 4), ins(OP_FOP, 15, 1, 2)}, 0, 0, 0, 0);
    tick(0, '0, 0, 0, 0, 0);
    drain();
    // R6 FP load feeds right FP op
    tick(1, {ins(OP_FOP, 17, 18, 19), ins(OP_FLD, 18, 12, 0)}, 0, 0, 0, 0);
    tick(0, '0, 0, 0, 1, 18);
    tick(0, '0, 0, 0, 0, 0);
    tick(0, '0, 0, 0, 0, 0);
    // R11 FP store pairs with FP op
    tick(1, {ins(OP_FOP, 20, 21, 22), ins(OP_FST, 0, 12, 23)}, 0, 0, 0, 0);
    // R10 empty slots
    tick(1, {ins(OP_FOP, 24, 25, 26), 32'd0}, 0, 0, 0, 0);
    tick(1, {32'd0, ins(OP_ALU, 27, 1, 2)}, 0, 0, 0, 0);
    tick(1, 64'd0, 0, 0, 0, 0);
    drain();
    // R7 same-cycle set and clear keeps r3 pending
    tick(1, {32'd0, ins(OP_ALU, 3, 1, 2)}, 1, 3, 0, 0);
    tick(1, {32'd0, ins(OP_ALU, 5, 3, 0)}, 0, 0, 0, 0);
    drain();
    // R2 integer register 0 never pending
    tick(1, {32'd0, ins(OP_ALU, 0, 1, 2)}, 0, 0, 0, 0);
    tick(1, {32'd0, ins(OP_ALU, 6, 0, 0)}, 0, 0, 0, 0);
    drain();

    cur = {rnd_right(), rnd_left()};
    for (int n = 0; n < 3000; n++) begin
      bit fv = ($urandom_range(0, 9) != 0);
      tick(fv, cur, $urandom_range(0, 1) == 1, $urandom_range(0, 3),
           $urandom_range(0, 1) == 1, $urandom_range(0, 3));
      if (last_adv) cur = {rnd_right(), rnd_left()};
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule